// File: doc/BRIEF.md
# Network Node Flit Sink with Request Detection

This block is the receive end of one node on an on-chip network. Data arrives as 32-bit phits, two per flit: the first phit is a header, the second carries the injection time stamp of the message it belongs to. From the header the block decides what kind of flit it holds: one-way, request or response. It checks the per-source sequence number, and on a request it offers the original source, destination and flit identifier, together with the time stamp, to the local traffic generator, which then builds the reply.

Latency is measured against a shared time input. A one-way flit is complete when its second phit is taken. A request-response exchange is complete when the second phit of the third response flit from that source is taken, so the round trip spans six response phits. Both kinds feed saturating 32-bit latency sums with their own completion counts. A counter of received payload bits supports throughput measurement. Sticky flags report out-of-order flits and flits whose second phit never arrived.

Top module: `rxs_node_sink`

## Requirements
- R1: A phit is taken on a clock edge where `i_phit_valid` and `o_phit_ready` are both high. Taken phits alternate header, then stamp. Each taken phit adds 32 to `o_bits`.
- R2: Header layout is [31:30] marker, [29] request flag, [28] response flag, [27:24] source, [23:20] destination, [19:13] sequence, [12:0] flit id. When the stamp phit of a flit with the request flag set is taken, `o_rsp_valid` is high from the next cycle. The offer carries that header's source, destination and flit id, and the stamp phit.
- R3: A flit whose request flag is clear never causes an offer.
- R4: The offer is a one-entry valid/ready hand-off. While it is pending and `i_rsp_ready` is low, its fields stay unchanged and `o_phit_ready` is low, so no phit is taken.
- R5: A flit is a response only when marker is 2'b11, the response flag is 1 and the request flag is 0. On the stamp phit of every third response flit from the same source, `o_rt_cnt` goes up by one and `i_time - stamp` is added to `o_rt_sum`.
- R6: A flit that is neither a request nor a response adds `i_time - stamp` (modulo 2^32, `i_time` as seen at the edge that takes its stamp phit) to `o_ow_sum` and adds one to `o_ow_cnt`.
- R7: Both latency sums saturate at 32'hFFFFFFFF and never wrap.
- R8: Each source has an expected sequence number, 0 after reset. A header whose sequence differs from it gives a one-cycle `o_order_pulse` and sets the sticky `o_err_order`. Either way, the expected value becomes the received sequence plus one, modulo 128.
- R9: After a header, up to `i_timeout` cycles without a valid phit are allowed. On the next such cycle the flit is dropped and `o_err_lost` is set: no latency, no offer. The next phit is treated as a header.
- R10: After reset `o_phit_ready` is 1, and `o_rsp_valid`, both error flags, all sums, counts and `o_bits` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_time | input | 32 | Network-wide cycle time |
| i_timeout | input | TO_W | Idle cycles allowed between header and stamp |
| i_phit_valid | input | 1 | Phit present |
| i_phit | input | 32 | Phit data |
| o_phit_ready | output | 1 | Phit can be taken |
| o_rsp_valid | output | 1 | Response request pending |
| i_rsp_ready | input | 1 | Generator takes the request |
| o_rsp_src | output | 4 | Source id of the request |
| o_rsp_dst | output | 4 | Destination id of the request |
| o_rsp_fid | output | 13 | Flit id of the request |
| o_rsp_stamp | output | 32 | Injection stamp of the request |
| o_order_pulse | output | 1 | One-cycle out-of-order indication |
| o_err_order | output | 1 | Sticky out-of-order flag |
| o_err_lost | output | 1 | Sticky lost-phit flag |
| o_bits | output | BIT_W | Received payload bits |
| o_ow_sum | output | 32 | Saturating one-way latency sum |
| o_ow_cnt | output | CNT_W | Completed one-way flits |
| o_rt_sum | output | 32 | Saturating round-trip latency sum |
| o_rt_cnt | output | CNT_W | Completed round trips |

## Verification
A wrong expected-sequence entry shows up as an `o_order_pulse` in the cycle right after the next header from that source, or as a missing pulse there. A bad response-group count shifts `o_rt_cnt` by one or more response flits, and this is visible as soon as the third flit of a group is taken. A wrong wait counter shows `o_err_lost` one cycle too early or too late, relative to the idle gap the bench controls. A lost or altered offer fails the scoreboard at the first hand-off.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int PHIT_W = 32;
  localparam int SRC_W  = 4;
  localparam int SEQ_W  = 7;
  localparam int FID_W  = 13;
  localparam int SUM_W  = 32;

  typedef struct packed {
    logic [1:0]       marker;
    logic             rq;
    logic             rp;
    logic [SRC_W-1:0] src;
    logic [SRC_W-1:0] dst;
    logic [SEQ_W-1:0] seq;
    logic [FID_W-1:0] fid;
  } hdr_t;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [SRC_W-1:0]  dst;
    logic [FID_W-1:0]  fid;
    logic [PHIT_W-1:0] stamp;
  } rsp_t;

  typedef enum logic [1:0] {K_ONEWAY, K_REQ, K_RSP} kind_t;

  function automatic kind_t classify(input hdr_t h);
    if (h.marker == 2'b11 && h.rp && !h.rq) return K_RSP;
    if (h.rq) return K_REQ;
    return K_ONEWAY;
  endfunction

  function automatic logic [SUM_W-1:0] sat_add(input logic [SUM_W-1:0] a,
                                               input logic [SUM_W-1:0] b);
    logic [SUM_W:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[SUM_W] ? {SUM_W{1'b1}} : t[SUM_W-1:0];
  endfunction

  function automatic logic [SUM_W-1:0] elapsed(input logic [SUM_W-1:0] now,
                                               input logic [SUM_W-1:0] stamp);
    return now - stamp;
  endfunction
endpackage

// File: rtl/rxs_seq_track.sv
module rxs_seq_track #(
  parameter int SRC_W = 4,
  parameter int SEQ_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_chk,
  input  logic [SRC_W-1:0] i_src,
  input  logic [SEQ_W-1:0] i_seq,
  output logic             o_pulse,
  output logic             o_sticky
);
  localparam int N_SRC = 1 << SRC_W;

  logic [SEQ_W-1:0] exp_q [N_SRC];
  logic             bad;

  assign bad = i_chk && (i_seq != exp_q[i_src]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SRC; s++) exp_q[s] <= '0;
      o_pulse  <= 1'b0;
      o_sticky <= 1'b0;
    end else begin
      o_pulse <= bad;
      if (bad) o_sticky <= 1'b1;
      if (i_chk) exp_q[i_src] <= i_seq + 1'b1;
    end
  end

  a_r8_pulse_flag: assert property (@(posedge clk) disable iff (!rst_n)
    o_pulse |-> o_sticky);
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    o_sticky |=> o_sticky);
endmodule

// File: rtl/rxs_rsp_slot.sv
module rxs_rsp_slot #(
  parameter int W = 53
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         i_load,
  input  logic [W-1:0] i_data,
  output logic         o_valid,
  input  logic         i_ready,
  output logic [W-1:0] o_data,
  output logic         o_can_take
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign o_can_take = !full_q || i_ready;
  assign o_valid    = full_q;
  assign o_data     = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (i_load) begin
      full_q <= 1'b1;
      data_q <= i_data;
    end else if (full_q && i_ready) begin
      full_q <= 1'b0;
    end
  end

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !i_ready) |=> (o_valid && $stable(o_data)));
  a_r4_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    i_load |-> o_can_take);
endmodule

// File: rtl/rxs_stats.sv
module rxs_stats
  import rxs_pkg::*;
#(
  parameter int BIT_W = 48,
  parameter int CNT_W = 24,
  parameter int NCH   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      i_phit_acc,
  input  logic [NCH-1:0]            i_done,
  input  logic [SUM_W-1:0]          i_lat,
  output logic [BIT_W-1:0]          o_bits,
  output logic [NCH-1:0][SUM_W-1:0] o_sum,
  output logic [NCH-1:0][CNT_W-1:0] o_cnt
);
  localparam logic [BIT_W-1:0] STEP = BIT_W'(PHIT_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) o_bits <= '0;
    else if (i_phit_acc) o_bits <= o_bits + STEP;
  end

  a_r1_bits_step: assert property (@(posedge clk) disable iff (!rst_n)
    i_phit_acc |=> (o_bits == $past(o_bits) + STEP));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        o_sum[g] <= '0;
        o_cnt[g] <= '0;
      end else if (i_done[g]) begin
        o_sum[g] <= sat_add(o_sum[g], i_lat);
        o_cnt[g] <= o_cnt[g] + 1'b1;
      end
    end

    a_r7_sum_mono: assert property (@(posedge clk) disable iff (!rst_n)
      i_done[g] |=> (o_sum[g] >= $past(o_sum[g])));
  end
endmodule

// File: rtl/rxs_node_sink.sv
module rxs_node_sink
  import rxs_pkg::*;
#(
  parameter int TO_W      = 16,
  parameter int BIT_W     = 48,
  parameter int CNT_W     = 24,
  parameter int RSP_FLITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       i_time,
  input  logic [TO_W-1:0]   i_timeout,
  input  logic              i_phit_valid,
  input  logic [31:0]       i_phit,
  output logic              o_phit_ready,
  output logic              o_rsp_valid,
  input  logic              i_rsp_ready,
  output logic [3:0]        o_rsp_src,
  output logic [3:0]        o_rsp_dst,
  output logic [12:0]       o_rsp_fid,
  output logic [31:0]       o_rsp_stamp,
  output logic              o_order_pulse,
  output logic              o_err_order,
  output logic              o_err_lost,
  output logic [BIT_W-1:0]  o_bits,
  output logic [31:0]       o_ow_sum,
  output logic [CNT_W-1:0]  o_ow_cnt,
  output logic [31:0]       o_rt_sum,
  output logic [CNT_W-1:0]  o_rt_cnt
);
  localparam int N_SRC = 1 << SRC_W;
  localparam int GRP_W = (RSP_FLITS > 1) ? $clog2(RSP_FLITS) : 1;
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(RSP_FLITS - 1);

  typedef enum logic {S_HEAD, S_BODY} st_t;

  st_t              state;
  kind_t            kind_q;
  logic [SRC_W-1:0] src_q, dst_q;
  logic [FID_W-1:0] fid_q;
  logic [TO_W-1:0]  wait_cnt;
  logic [GRP_W-1:0] grp_q [N_SRC];

  hdr_t             hdr_in;
  logic [SUM_W-1:0] lat;
  rsp_t             rsp_in, rsp_out;
  logic             can_take;

  // named events for the checks below
  logic phit_acc, head_acc, body_acc, lost_evt, ow_done, rt_done, req_load, grp_end;

  assign hdr_in   = hdr_t'(i_phit);
  assign lat      = elapsed(i_time, i_phit);
  assign phit_acc = i_phit_valid && can_take;
  assign head_acc = phit_acc && state == S_HEAD;
  assign body_acc = phit_acc && state == S_BODY;
  assign lost_evt = state == S_BODY && !i_phit_valid && wait_cnt == i_timeout;
  assign grp_end  = grp_q[src_q] == GRP_LAST;
  assign ow_done  = body_acc && kind_q == K_ONEWAY;
  assign rt_done  = body_acc && kind_q == K_RSP && grp_end;
  assign req_load = body_acc && kind_q == K_REQ;
  assign rsp_in   = '{src: src_q, dst: dst_q, fid: fid_q, stamp: i_phit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_HEAD;
      kind_q   <= K_ONEWAY;
      src_q    <= '0;
      dst_q    <= '0;
      fid_q    <= '0;
      wait_cnt <= '0;
    end else if (head_acc) begin
      state    <= S_BODY;
      kind_q   <= classify(hdr_in);
      src_q    <= hdr_in.src;
      dst_q    <= hdr_in.dst;
      fid_q    <= hdr_in.fid;
      wait_cnt <= '0;
    end else if (body_acc || lost_evt) begin
      state <= S_HEAD;
    end else if (state == S_BODY && !i_phit_valid) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SRC; s++) grp_q[s] <= '0;
    end else if (body_acc && kind_q == K_RSP) begin
      grp_q[src_q] <= grp_end ? '0 : grp_q[src_q] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) o_err_lost <= 1'b0;
    else if (lost_evt) o_err_lost <= 1'b1;
  end

  rxs_seq_track #(.SRC_W(SRC_W), .SEQ_W(SEQ_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .i_chk(head_acc), .i_src(hdr_in.src),
    .i_seq(hdr_in.seq), .o_pulse(o_order_pulse), .o_sticky(o_err_order));

  rxs_rsp_slot #(.W($bits(rsp_t))) i_slot (
    .clk(clk), .rst_n(rst_n), .i_load(req_load), .i_data(rsp_in),
    .o_valid(o_rsp_valid), .i_ready(i_rsp_ready), .o_data(rsp_out),
    .o_can_take(can_take));

  logic [1:0][SUM_W-1:0] sums;
  logic [1:0][CNT_W-1:0] cnts;

  rxs_stats #(.BIT_W(BIT_W), .CNT_W(CNT_W), .NCH(2)) i_stats (
    .clk(clk), .rst_n(rst_n), .i_phit_acc(phit_acc), .i_done({rt_done, ow_done}),
    .i_lat(lat), .o_bits(o_bits), .o_sum(sums), .o_cnt(cnts));

  assign o_phit_ready = can_take;
  assign o_rsp_src    = rsp_out.src;
  assign o_rsp_dst    = rsp_out.dst;
  assign o_rsp_fid    = rsp_out.fid;
  assign o_rsp_stamp  = rsp_out.stamp;
  assign o_ow_sum     = sums[0];
  assign o_ow_cnt     = cnts[0];
  assign o_rt_sum     = sums[1];
  assign o_rt_cnt     = cnts[1];

  a_r2_offer_after_request: assert property (@(posedge clk) disable iff (!rst_n)
    req_load |=> o_rsp_valid);
  a_r3_no_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (body_acc && kind_q != K_REQ && !o_rsp_valid) |=> !o_rsp_valid);
  a_r9_lost_flag: assert property (@(posedge clk) disable iff (!rst_n)
    lost_evt |=> (o_err_lost && !body_acc));
  a_r5_rt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (o_rt_cnt != $past(o_rt_cnt)) |-> $past(rt_done));
endmodule

// File: tb/test_rxs_node_sink.sv
`timescale 1ns/1ps
module test_rxs_node_sink;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tnow = '0;
  logic [15:0] i_timeout = 16'd5;
  logic        i_phit_valid = 1'b0;
  logic [31:0] i_phit = '0;
  logic        rsp_rdy = 1'b0;
  logic        o_phit_ready, o_rsp_valid, o_order_pulse, o_err_order, o_err_lost;
  logic [3:0]  o_rsp_src, o_rsp_dst;
  logic [12:0] o_rsp_fid;
  logic [31:0] o_rsp_stamp, o_ow_sum, o_rt_sum;
  logic [47:0] o_bits;
  logic [23:0] o_ow_cnt, o_rt_cnt;

  always #2 clk = ~clk;
  always @(posedge clk) tnow <= tnow + 1;

  rxs_node_sink i_rxs_node_sink (
    .clk(clk), .rst_n(rst_n), .i_time(tnow), .i_timeout(i_timeout),
    .i_phit_valid(i_phit_valid), .i_phit(i_phit), .o_phit_ready(o_phit_ready),
    .o_rsp_valid(o_rsp_valid), .i_rsp_ready(rsp_rdy), .o_rsp_src(o_rsp_src),
    .o_rsp_dst(o_rsp_dst), .o_rsp_fid(o_rsp_fid), .o_rsp_stamp(o_rsp_stamp),
    .o_order_pulse(o_order_pulse), .o_err_order(o_err_order), .o_err_lost(o_err_lost),
    .o_bits(o_bits), .o_ow_sum(o_ow_sum), .o_ow_cnt(o_ow_cnt),
    .o_rt_sum(o_rt_sum), .o_rt_cnt(o_rt_cnt));

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  logic [6:0]  m_seq [16];
  logic [1:0]  m_grp [16];
  logic [47:0] m_bits = '0;
  logic [31:0] m_ow_sum = '0, m_rt_sum = '0;
  int          m_ow_cnt = 0, m_rt_cnt = 0;
  logic [31:0] tacc;
  logic [52:0] rsp_q [$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_sat(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > 33'h0_FFFF_FFFF) ? 32'hFFFF_FFFF : s[31:0];
  endfunction

  // scoreboard monitor: response requests handed to the generator
  always @(negedge clk) begin
    if (rst_n && o_rsp_valid && rsp_rdy) begin
      if (rsp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 unexpected offer actual=%0h expected=none",
                 {o_rsp_src, o_rsp_dst, o_rsp_fid, o_rsp_stamp});
      end else begin
        check("R2 offer fields", {11'd0, o_rsp_src, o_rsp_dst, o_rsp_fid, o_rsp_stamp},
              {11'd0, rsp_q.pop_front()});
      end
    end
  end

  task automatic send_phit(input logic [31:0] d);
    @(negedge clk);
    i_phit_valid = 1'b1;
    i_phit = d;
    while (!o_phit_ready) @(negedge clk);
    tacc = tnow;
    @(posedge clk);
    #1 i_phit_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic flit(input logic [1:0] mk, input logic rq, input logic rp,
                      input logic [3:0] src, input logic [3:0] dst, input logic [6:0] seq,
                      input logic [12:0] fid, input logic [31:0] stamp, input int gap);
    logic bad;
    logic [31:0] lat;
    bad = (seq != m_seq[src]);
    m_seq[src] = seq + 7'd1;
    send_phit({mk, rq, rp, src, dst, seq, fid});
    m_bits += 48'd32;
    check("R8 order pulse", {63'd0, o_order_pulse}, {63'd0, bad});
    idle(gap);
    send_phit(stamp);
    m_bits += 48'd32;
    lat = tacc - stamp;
    if (mk == 2'b11 && rp && !rq) begin
      if (m_grp[src] == 2'd2) begin
        m_grp[src] = 2'd0;
        m_rt_sum = m_sat(m_rt_sum, lat);
        m_rt_cnt++;
      end else m_grp[src] = m_grp[src] + 2'd1;
    end else if (rq) begin
      rsp_q.push_back({src, dst, fid, stamp});
    end else begin
      m_ow_sum = m_sat(m_ow_sum, lat);
      m_ow_cnt++;
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [47:0] snap;
    logic [31:0] s_rt;
    for (int i = 0; i < 16; i++) begin m_seq[i] = '0; m_grp[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10 ready", {63'd0, o_phit_ready}, 64'd1);
    check("R10 offer", {63'd0, o_rsp_valid}, 64'd0);
    check("R10 flags", {62'd0, o_err_order, o_err_lost}, 64'd0);
    check("R10 counters", {16'd0, o_bits} | {32'd0, o_ow_sum} | {32'd0, o_rt_sum}, 64'd0);

    // R6 one-way latency, R1 bits, R3 no offer
    flit(2'b00, 0, 0, 4'd1, 4'd2, 7'd0, 13'h0011, tnow - 4, 0);
    flit(2'b00, 0, 0, 4'd2, 4'd3, 7'd0, 13'h0022, tnow - 9, 2);
    flit(2'b00, 0, 0, 4'd1, 4'd4, 7'd1, 13'h0033, tnow, 1);
    @(negedge clk);
    check("R6 ow count", {40'd0, o_ow_cnt}, 64'(m_ow_cnt));
    check("R6 ow sum", {32'd0, o_ow_sum}, {32'd0, m_ow_sum});
    check("R1 bits", {16'd0, o_bits}, {16'd0, m_bits});
    check("R3 no offer after one-way", {63'd0, o_rsp_valid}, 64'd0);
    check("R8 no order error", {63'd0, o_err_order}, 64'd0);

    // R2 request offer, R4 hold and back-pressure
    flit(2'b00, 1, 0, 4'd3, 4'd9, 7'd0, 13'h1ABC, tnow - 6, 0);
    @(negedge clk);
    check("R2 offer raised", {63'd0, o_rsp_valid}, 64'd1);
    snap = m_bits;
    fork
      flit(2'b00, 0, 0, 4'd1, 4'd5, 7'd2, 13'h0044, tnow - 2, 0);
      begin
        repeat (4) begin
          @(negedge clk);
          check("R4 ready low while pending", {63'd0, o_phit_ready}, 64'd0);
          check("R4 nothing taken", {16'd0, o_bits}, {16'd0, snap});
          check("R4 offer held", {51'd0, o_rsp_fid}, 64'h1ABC);
        end
        @(posedge clk);
        #1 rsp_rdy = 1'b1;
      end
    join
    flit(2'b00, 1, 0, 4'd8, 4'd1, 7'd0, 13'h0FFF, tnow - 30, 1);
    flit(2'b11, 1, 1, 4'd10, 4'd11, 7'd0, 13'h0ABC, tnow - 3, 0);
    repeat (3) @(negedge clk);
    check("R2 all offers delivered", 64'(rsp_q.size()), 64'd0);

    // R5 response group and decode
    s_rt = tnow - 50;
    flit(2'b11, 0, 1, 4'd6, 4'd0, 7'd0, 13'h0100, s_rt, 0);
    flit(2'b11, 0, 1, 4'd6, 4'd0, 7'd1, 13'h0100, s_rt, 2);
    @(negedge clk);
    check("R5 not done after two flits", {40'd0, o_rt_cnt}, 64'd0);
    flit(2'b11, 0, 1, 4'd6, 4'd0, 7'd2, 13'h0100, s_rt, 3);
    flit(2'b11, 0, 0, 4'd7, 4'd0, 7'd0, 13'h0101, tnow - 5, 0);
    flit(2'b00, 0, 1, 4'd7, 4'd0, 7'd1, 13'h0102, tnow - 8, 0);
    @(negedge clk);
    check("R5 rt count", {40'd0, o_rt_cnt}, 64'(m_rt_cnt));
    check("R5 rt sum", {32'd0, o_rt_sum}, {32'd0, m_rt_sum});
    check("R5 non-response markers one-way", {40'd0, o_ow_cnt}, 64'(m_ow_cnt));
    check("R3 no offer from responses", {63'd0, o_rsp_valid}, 64'd0);

    // R9 timeout edge: exactly i_timeout idle cycles is fine
    flit(2'b00, 0, 0, 4'd1, 4'd2, 7'd3, 13'h0200, tnow - 1, 5);
    @(negedge clk);
    check("R9 no loss at limit", {63'd0, o_err_lost}, 64'd0);
    check("R9 flit counted", {40'd0, o_ow_cnt}, 64'(m_ow_cnt));
    // R9 one cycle more loses the flit
    send_phit({2'b00, 1'b0, 1'b0, 4'd2, 4'd3, m_seq[2], 13'h0055});
    m_seq[2] = m_seq[2] + 7'd1;
    m_bits += 48'd32;
    idle(5);
    @(negedge clk);
    check("R9 still waiting", {63'd0, o_err_lost}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    check("R9 loss flagged", {63'd0, o_err_lost}, 64'd1);
    check("R9 lost flit not counted", {40'd0, o_ow_cnt}, 64'(m_ow_cnt));
    flit(2'b00, 0, 0, 4'd2, 4'd3, m_seq[2], 13'h0056, tnow - 2, 0);
    @(negedge clk);
    check("R9 next phit is header", {40'd0, o_ow_cnt}, 64'(m_ow_cnt));
    check("R9 sum after loss", {32'd0, o_ow_sum}, {32'd0, m_ow_sum});

    // R8 sequence mismatch, resync and wrap
    flit(2'b00, 0, 0, 4'd4, 4'd1, 7'd3, 13'h0300, tnow - 1, 0);
    @(negedge clk);
    check("R8 sticky order flag", {63'd0, o_err_order}, 64'd1);
    flit(2'b00, 0, 0, 4'd4, 4'd1, 7'd4, 13'h0301, tnow - 1, 0);
    flit(2'b00, 0, 0, 4'd4, 4'd1, 7'd5, 13'h0302, tnow - 1, 0);
    flit(2'b00, 0, 0, 4'd11, 4'd1, 7'd127, 13'h0303, tnow - 1, 0);
    flit(2'b00, 0, 0, 4'd11, 4'd1, 7'd0, 13'h0304, tnow - 1, 0);

    // R7 saturation
    flit(2'b00, 0, 0, 4'd9, 4'd1, 7'd0, 13'h0400, tnow + 1000, 0);
    flit(2'b00, 0, 0, 4'd9, 4'd1, 7'd1, 13'h0401, tnow + 1000, 0);
    @(negedge clk);
    check("R7 saturated", {32'd0, o_ow_sum}, 64'hFFFF_FFFF);
    flit(2'b00, 0, 0, 4'd9, 4'd1, 7'd2, 13'h0402, tnow - 3, 0);
    @(negedge clk);
    check("R7 stays saturated", {32'd0, o_ow_sum}, {32'd0, m_ow_sum});
    check("R6 final ow count", {40'd0, o_ow_cnt}, 64'(m_ow_cnt));
    check("R1 final bits", {16'd0, o_bits}, {16'd0, m_bits});
    check("R2 queue drained", 64'(rsp_q.size()), 64'd0);
    finish_run();
  end
endmodule